// File: doc/BRIEF.md
# PAM4 Transmit Precoder and Level Mapper

This block sits in the transmit path of one serial lane. Each cycle it may accept a 2-bit data symbol, marked by a valid strobe, and it turns that symbol into a small signed integer that names one of four amplitude levels. A downstream equalizing filter or DAC then uses that integer. The levels are -3, -1, +1 and +3. They stand for the normalized amplitudes -1, -1/3, +1/3 and +1.

In high-rate operation the precode-enable input is held high. The block then first XORs each bit of the incoming symbol with the matching bit of the last precoded symbol it sent. This limits error propagation in a receiver that uses decision feedback. At lower rates the enable is held low, and the symbol goes to the mapper unchanged. The mapper uses a Gray assignment, so neighbouring levels differ in a single bit. The precoder memory is cleared by reset and by any change of the enable input. The result is registered, so output valid and level appear one cycle after the input.

Top module: `pam4_tx_mapper`

## Requirements
- R1: While reset is held and on the first cycle after it, out_valid is 0 and out_level is 0.
- R2: out_valid in a cycle equals in_valid from the previous cycle.
- R3: With precode_en low, an accepted symbol is mapped with no precoding. The precoder memory has no effect on it.
- R4: Mapping of the 2-bit value (MSB first) to out_level is Gray: 00→-3, 01→-1, 11→+1, 10→+3. Neighbouring levels differ in exactly one bit.
- R5: With precode_en high, the value mapped is in_sym XOR the precoded value of the last accepted symbol, bit by bit.
- R6: The precoder memory changes only on accepted symbols (in_valid high). A cycle with in_valid low leaves it as it was.
- R7: A change of precode_en, with or without a valid symbol, clears the precoder memory. The next precoded symbol is therefore referenced to 00.
- R8: Whenever out_valid is high, out_level is one of -3, -1, +1, +3.
- R9: After a cycle with in_valid low, out_level keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Lane clock |
| rst_n | input | 1 | Synchronous reset, active low |
| precode_en | input | 1 | 1 = apply the XOR precoder, 0 = bypass it |
| in_valid | input | 1 | in_sym holds a symbol this cycle |
| in_sym | input | 2 | Data symbol, MSB first |
| out_valid | output | 1 | out_level holds a fresh level |
| out_level | output | 3 | Signed level code (-3, -1, +1, +3), two's complement |

## Verification
A wrong precoder memory does not show at once. It appears on the next accepted precoded symbol, one cycle after that symbol is presented, as a level that belongs to a different XOR reference. The bench therefore places idle cycles and enable changes right before precoded symbols whose expected level depends on whether the memory was held or cleared. A mapping or latency error shows at the output one cycle after the input that causes it. Bypass symbols sent after precoded traffic expose any leakage of the memory into the bypass path.

// File: rtl/pam4_pkg.sv
// Shared constants for the PAM4 transmit mapper.
// Assumes a symbol of SYM_W bits selects one of 2**SYM_W levels.
package pam4_pkg;
    localparam int PAM_SYM_W = 2;
    localparam int PAM_LVL_W = PAM_SYM_W + 1;
endpackage

// File: rtl/pam4_precoder.sv
// Per-bit XOR precoder with memory of the last precoded symbol.
// Assumes: memory updates only on accepted symbols. Any change of the
// enable clears the reference to zero. When disabled, the symbol passes
// through unchanged.
module pam4_precoder #(
    parameter int SYM_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             valid,
    input  logic [SYM_W-1:0] sym,
    output logic [SYM_W-1:0] coded
);
    logic             en_q;
    logic [SYM_W-1:0] mem_q;
    logic [SYM_W-1:0] ref_sym;
    logic [SYM_W-1:0] xored;
    logic             mode_flip;

    assign mode_flip = en ^ en_q;
    assign ref_sym   = mode_flip ? '0 : mem_q;

    // One XOR per symbol bit; bits are independent
    for (genvar b = 0; b < SYM_W; b++) begin : g_bit
        assign xored[b] = sym[b] ^ ref_sym[b];
    end

    // Select precoded or raw value
    always_comb begin
        coded = en ? xored : sym;
    end

    // Track enable and keep the last precoded symbol
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            mem_q <= '0;
        end else begin
            en_q <= en;
            if (valid && en)
                mem_q <= xored;
            else if (mode_flip)
                mem_q <= '0;
        end
    end
endmodule

// File: rtl/pam4_gray_mapper.sv
// Combinational Gray-to-level mapper.
// Gray value -> binary rank r, level = 2r - (2**SYM_W - 1), formed by
// appending a 1 and flipping the top bit (no adder needed).
module pam4_gray_mapper #(
    parameter int SYM_W = 2,
    localparam int LVL_W = SYM_W + 1
) (
    input  logic [SYM_W-1:0]        gray,
    output logic signed [LVL_W-1:0] level
);
    logic [SYM_W-1:0] rank;

    // Gray to binary: prefix XOR from the MSB down
    assign rank[SYM_W-1] = gray[SYM_W-1];
    for (genvar b = SYM_W - 2; b >= 0; b--) begin : g_rank
        assign rank[b] = rank[b+1] ^ gray[b];
    end

    // Offset-binary to two's complement odd level
    always_comb begin
        level = {~rank[SYM_W-1], rank[SYM_W-2:0], 1'b1};
    end
endmodule

// File: rtl/pam4_out_stage.sv
// Output register: one cycle of latency. The level holds when no symbol
// is accepted. Reset gives valid 0 and level 0.
module pam4_out_stage #(
    parameter int LVL_W = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    valid_in,
    input  logic signed [LVL_W-1:0] level_in,
    output logic                    valid_out,
    output logic signed [LVL_W-1:0] level_out
);
    // Register valid every cycle, level only on accepted symbols
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_out <= 1'b0;
            level_out <= '0;
        end else begin
            valid_out <= valid_in;
            if (valid_in)
                level_out <= level_in;
        end
    end
endmodule

// File: rtl/pam4_tx_mapper.sv
// PAM4 lane transmit precoder and level mapper (top).
// Data path: precoder -> Gray mapper -> output register.
// Assumes the symbol width is at least 2 bits.
module pam4_tx_mapper #(
    parameter int SYM_W = pam4_pkg::PAM_SYM_W,
    localparam int LVL_W = SYM_W + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    precode_en,
    input  logic                    in_valid,
    input  logic [SYM_W-1:0]        in_sym,
    output logic                    out_valid,
    output logic signed [LVL_W-1:0] out_level
);
    logic [SYM_W-1:0]        coded;
    logic signed [LVL_W-1:0] level_c;

    pam4_precoder #(.SYM_W(SYM_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (precode_en),
        .valid (in_valid),
        .sym   (in_sym),
        .coded (coded)
    );

    pam4_gray_mapper #(.SYM_W(SYM_W)) u_map (
        .gray  (coded),
        .level (level_c)
    );

    pam4_out_stage #(.LVL_W(LVL_W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid_in  (in_valid),
        .level_in  (level_c),
        .valid_out (out_valid),
        .level_out (out_level)
    );
endmodule

// File: rtl/pam4_tx_mapper_chk.sv
// Port-level checker for pam4_tx_mapper (2-bit symbols), bound below.
module pam4_tx_mapper_chk (
    input logic              clk,
    input logic              rst_n,
    input logic              precode_en,
    input logic              in_valid,
    input logic [1:0]        in_sym,
    input logic              out_valid,
    input logic signed [2:0] out_level
);
    function automatic logic signed [2:0] ref_level(input logic [1:0] s);
        case (s)
            2'b00:   ref_level = -3'sd3;
            2'b01:   ref_level = -3'sd1;
            2'b11:   ref_level = 3'sd1;
            default: ref_level = 3'sd3;
        endcase
    endfunction

    // R2: accepted input gives valid output next cycle
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2: idle input gives idle output next cycle
    a_r2_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R3 / R4: bypass symbol maps straight through the Gray table
    a_r3_bypass_map: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !precode_en) |=> (out_level == ref_level($past(in_sym))));

    // R8: only legal levels when valid
    a_r8_legal_level: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_level == -3'sd3 || out_level == -3'sd1 ||
                       out_level == 3'sd1  || out_level == 3'sd3));

    // R9: level holds across an idle cycle
    a_r9_hold_level: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_level));
endmodule

bind pam4_tx_mapper pam4_tx_mapper_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .precode_en (precode_en),
    .in_valid   (in_valid),
    .in_sym     (in_sym),
    .out_valid  (out_valid),
    .out_level  (out_level)
);

// File: tb/pam4_tx_mapper_test.sv
`timescale 1ns/1ps
module pam4_tx_mapper_test;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              precode_en = 1'b0;
    logic              in_valid = 1'b0;
    logic [1:0]        in_sym = 2'b00;
    logic              out_valid;
    logic signed [2:0] out_level;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit finished = 0;

    pam4_tx_mapper uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .precode_en (precode_en),
        .in_valid   (in_valid),
        .in_sym     (in_sym),
        .out_valid  (out_valid),
        .out_level  (out_level)
    );

    always #2.5 clk = ~clk;

    typedef struct packed {
        logic              en;
        logic              v;
        logic [1:0]        sym;
        logic signed [2:0] lvl;
        logic [3:0]        req;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t TBL [NV] = '{
        '{1'b0, 1'b1, 2'b00, -3'sd3, 4'd4}, // R4 bypass 00
        '{1'b0, 1'b1, 2'b01, -3'sd1, 4'd4}, // R4 bypass 01
        '{1'b0, 1'b1, 2'b11,  3'sd1, 4'd4}, // R4 bypass 11
        '{1'b0, 1'b1, 2'b10,  3'sd3, 4'd3}, // R3 bypass 10
        '{1'b1, 1'b1, 2'b01, -3'sd1, 4'd7}, // R7 enable rise, ref 00
        '{1'b1, 1'b1, 2'b01, -3'sd3, 4'd5}, // R5 01^01=00
        '{1'b1, 1'b1, 2'b11,  3'sd1, 4'd5}, // R5 11^00=11
        '{1'b1, 1'b1, 2'b10, -3'sd1, 4'd5}, // R5 10^11=01
        '{1'b1, 1'b0, 2'b11, -3'sd1, 4'd9}, // R9 idle holds level
        '{1'b1, 1'b1, 2'b00, -3'sd1, 4'd6}, // R6 memory held at 01
        '{1'b1, 1'b1, 2'b11,  3'sd3, 4'd5}, // R5 11^01=10
        '{1'b0, 1'b1, 2'b00, -3'sd3, 4'd3}, // R3 bypass ignores memory
        '{1'b1, 1'b1, 2'b11,  3'sd1, 4'd7}, // R7 re-enable, ref 00
        '{1'b1, 1'b1, 2'b11, -3'sd3, 4'd5}, // R5 11^11=00
        '{1'b1, 1'b1, 2'b10,  3'sd3, 4'd5}, // R5 10^00=10
        '{1'b0, 1'b0, 2'b00,  3'sd3, 4'd7}, // R7 idle fall clears
        '{1'b1, 1'b0, 2'b00,  3'sd3, 4'd7}, // R7 idle rise clears
        '{1'b1, 1'b1, 2'b01, -3'sd1, 4'd7}  // R7 ref 00 (not 10)
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, $signed(act), $signed(exp));
        end
    endtask

    task automatic step(input logic en, input logic v, input logic [1:0] s);
        precode_en = en;
        in_valid   = v;
        in_sym     = s;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wrap_up();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
            wrap_up();
        end
    end

    initial begin
        // R1: during reset
        repeat (3) @(negedge clk);
        check("R1 valid in reset", {7'd0, out_valid}, 8'd0);
        check("R1 level in reset", {{5{out_level[2]}}, out_level}, 8'd0);
        rst_n = 1'b1;
        // R1: first cycle after reset, idle input
        step(1'b0, 1'b0, 2'b00);
        check("R1 valid after reset", {7'd0, out_valid}, 8'd0);
        check("R1 level after reset", {{5{out_level[2]}}, out_level}, 8'd0);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            step(TBL[i].en, TBL[i].v, TBL[i].sym);
            check($sformatf("R2 valid vec %0d", i), {7'd0, out_valid}, {7'd0, TBL[i].v});
            check($sformatf("R%0d level vec %0d", TBL[i].req, i),
                  {{5{out_level[2]}}, out_level}, {{5{TBL[i].lvl[2]}}, TBL[i].lvl});
        end

        // R8: precoded output legal over all symbol pairs
        for (int a = 0; a < 4; a++) begin
            step(1'b1, 1'b1, a[1:0]);
            check("R8 legal level", {7'd0, (out_level == -3'sd3 || out_level == -3'sd1 ||
                  out_level == 3'sd1 || out_level == 3'sd3)}, 8'd1);
        end

        // R1: reset mid-run clears output and memory
        step(1'b1, 1'b1, 2'b10);
        rst_n = 1'b0;
        step(1'b1, 1'b1, 2'b11);
        check("R1 valid on mid reset", {7'd0, out_valid}, 8'd0);
        check("R1 level on mid reset", {{5{out_level[2]}}, out_level}, 8'd0);
        rst_n = 1'b1;
        step(1'b1, 1'b1, 2'b11); // ref 00 -> 11 -> +1
        check("R5 first after reset", {{5{out_level[2]}}, out_level}, 8'd1);
        step(1'b1, 1'b0, 2'b00);
        check("R2 idle after burst", {7'd0, out_valid}, 8'd0);
        wrap_up();
    end
endmodule